// File: doc/BRIEF.md
# Smart Card Character Transceiver

This block moves single characters over the one-wire, half-duplex I/O line of an ISO 7816 style smart card. A character is a low start bit, eight data bits and one parity bit. Every bit lasts one elementary time unit (etu), and an etu is a programmable number of clock cycles. The block only pulls the line low or lets it float high. It reads the line back through `line_in`.

Software picks the coding convention. Direct convention is non-inverted and least significant bit first. Inverse convention inverts the data bits and sends the most significant bit first. A separate control flips the sense of the parity bit. In normal mode a receiver that sees bad parity signals the error on the line, and a transmitter that sees such a signal sends the character again. Block transfer mode has no error signalling and no retransmission, and it uses a shorter frame.

Transmit bytes enter on a valid/ready pair. A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high, and `tx_data` must stay steady until then. `tx_ready` is low while a character is being sent and also while one is being received. Received bytes leave on a valid/ready pair. `rx_valid` stays high, with `rx_data` held, until a cycle in which `rx_ready` is high. The line cannot be stalled, so a character that completes while the previous byte is still waiting is dropped. This includes the case where that byte is taken in the same cycle.

Top module: `sc_xcvr`

## Requirements
- R1: Direct convention (`cfg_inverse`=0): a data bit of 1 is the released (high) line. Data bits go out and are taken in least significant bit first, so 0x3B with even parity appears as line bits 0,1,1,0,1,1,1,0,0,1 (start bit first).
- R2: Inverse convention (`cfg_inverse`=1): data bits are inverted on the line and sent most significant bit first. The line sequence low,high,high,low,low,low,low,low,low,high with `cfg_par_flip`=1 carries 0x3F.
- R3: The line parity bit is the XOR of the eight data bits as they appear on the line, XORed with `cfg_par_flip`. A received character whose parity differs from this value has a parity error.
- R4: After a byte is accepted, the start bit is driven in the next cycle, and each bit lasts `cfg_etu_div` cycles (even, at least 4). `tx_end` is low while sending. In normal mode with no error signal, `tx_end` returns high 12 etu after the first start-bit cycle. With nothing in progress, the line is released.
- R5: In normal mode the transmitter samples the line at 10.5 etu. If the line is low there, it sets `err_sig_flag` and starts the same character again at 13 etu. It resends at most MAX_RETRY times, and after the last try it ends at 12 etu.
- R6: In block mode the transmitter never samples for an error and never resends. `tx_end` returns high 11.5 etu after the first start-bit cycle, which leaves at least 1 etu of guard after parity.
- R7: The receiver starts on a high-to-low line transition. It samples each bit at the middle of its etu, and it abandons a start bit that reads high at its middle.
- R8: In normal mode, a received parity error sets `par_err_flag`. The receiver pulls the line low for one etu, starting 10 etu after the start edge, and the byte is not delivered.
- R9: In block mode, a received parity error sets `par_err_flag`, drives nothing on the line, and the byte is still delivered.
- R10: The two flags stay set until their clear input is pulsed. A set and a clear in the same cycle leave the flag set. `err_sig_flag` reads 0 while `cfg_block`=1.
- R11: `rx_valid` and `rx_data` hold until `rx_ready`. A character that completes while `rx_valid` is high is dropped.
- R12: The receiver ignores the line while the transmitter is busy, and `tx_ready` is low while a character is being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_etu_div | input | ETU_W | Clock cycles per etu (even, at least 4) |
| cfg_inverse | input | 1 | 1 selects inverse convention |
| cfg_par_flip | input | 1 | Inverts the parity bit in both directions |
| cfg_block | input | 1 | 1 selects block transfer mode |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter can take a byte |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte waiting |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Received byte |
| tx_end | output | 1 | High when no transmission is in progress |
| par_err_flag | output | 1 | Sticky receive parity error |
| par_err_clr | input | 1 | Clears par_err_flag |
| err_sig_flag | output | 1 | Sticky error signal seen while sending |
| err_sig_clr | input | 1 | Clears err_sig_flag |
| line_in | input | 1 | Sampled state of the I/O line |
| line_drive_low | output | 1 | 1 pulls the line low, 0 releases it |

## Verification
A parity error can set `par_err_flag` on the same edge where software pulses `par_err_clr`. The bench raises the clear exactly in the parity-sample cycle of a bad block-mode character and then requires the flag to read 1. A later lone clear must read 0. The other collision is a character that completes while the previous byte is still unread. The bench sends two characters back to back without taking the first, and expects the first byte to stay intact and the second to be dropped.

// File: rtl/sc_pkg.sv
package sc_pkg;
  // Line order and polarity of the data bits: bit i is the i-th data bit on the wire.
  // The mapping is its own inverse, so it serves both directions.
  function automatic logic [7:0] sc_line_map(input logic [7:0] d, input logic inv);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = inv ? ~d[7-i] : d[i];
    return r;
  endfunction

  function automatic logic sc_line_par(input logic [7:0] lb, input logic flip);
    return (^lb) ^ flip;
  endfunction
endpackage

// File: rtl/sc_flag.sv
module sc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/sc_tx.sv
module sc_tx #(
  parameter int ETU_W     = 12,
  parameter int MAX_RETRY = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ETU_W-1:0] etu_div,
  input  logic             inv,
  input  logic             flip,
  input  logic             blk,
  input  logic             start,
  input  logic [7:0]       data,
  input  logic             line_in,
  output logic             busy,
  output logic             drv_low,
  output logic             err_seen
);
  import sc_pkg::*;
  localparam int RW = $clog2(MAX_RETRY + 1);

  logic [3:0]       bit_q;
  logic [ETU_W-1:0] cnt_q;
  logic [7:0]       lb_q;
  logic             par_q, nack_q;
  logic [RW-1:0]    retry_q;
  logic [ETU_W-1:0] half, half_m1, last;
  logic [2:0]       idx;

  assign half    = etu_div >> 1;
  assign half_m1 = half - 1'b1;
  assign last    = etu_div - 1'b1;
  assign idx     = bit_q[2:0] - 3'd1;

  // Error window: middle of the first guard etu, normal mode only.
  assign err_seen = busy && !blk && (bit_q == 4'd10) && (cnt_q == half) && !line_in;

  always_comb begin
    drv_low = 1'b0;
    if (busy) begin
      if (bit_q == 4'd0)                         drv_low = 1'b1;
      else if (bit_q >= 4'd1 && bit_q <= 4'd8)   drv_low = !lb_q[idx];
      else if (bit_q == 4'd9)                    drv_low = !par_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bit_q   <= '0;
      cnt_q   <= '0;
      lb_q    <= '0;
      par_q   <= 1'b0;
      nack_q  <= 1'b0;
      retry_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        bit_q   <= '0;
        cnt_q   <= '0;
        lb_q    <= sc_line_map(data, inv);
        par_q   <= sc_line_par(sc_line_map(data, inv), flip);
        nack_q  <= 1'b0;
        retry_q <= '0;
      end
    end else begin
      if (err_seen) nack_q <= 1'b1;
      if (blk && bit_q == 4'd11 && cnt_q == half_m1) begin
        busy <= 1'b0;                       // 11.5 etu frame end
      end else if (cnt_q == last) begin
        cnt_q <= '0;
        if (bit_q == 4'd11) begin
          if (nack_q && retry_q != RW'(MAX_RETRY)) bit_q <= 4'd12;
          else                                     busy  <= 1'b0;
        end else if (bit_q == 4'd12) begin
          bit_q   <= '0;                    // resend same character
          nack_q  <= 1'b0;
          retry_q <= retry_q + 1'b1;
        end else begin
          bit_q <= bit_q + 4'd1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sc_rx.sv
module sc_rx #(
  parameter int ETU_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ETU_W-1:0] etu_div,
  input  logic             inv,
  input  logic             flip,
  input  logic             blk,
  input  logic             enable,
  input  logic             line_in,
  input  logic             rx_ready,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             busy,
  output logic             drv_low,
  output logic             par_err
);
  import sc_pkg::*;

  logic             prev_q, bad_q;
  logic [3:0]       bit_q;
  logic [ETU_W-1:0] cnt_q;
  logic [7:0]       sh_q;
  logic [ETU_W-1:0] half, last;
  logic [2:0]       idx;
  logic             bad_now, mid;

  assign half    = etu_div >> 1;
  assign last    = etu_div - 1'b1;
  assign idx     = bit_q[2:0] - 3'd1;
  assign mid     = busy && (cnt_q == half);
  assign bad_now = sc_line_par(sh_q, flip) != line_in;
  assign par_err = mid && (bit_q == 4'd9) && bad_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b1;
      busy     <= 1'b0;
      bit_q    <= '0;
      cnt_q    <= '0;
      sh_q     <= '0;
      bad_q    <= 1'b0;
      drv_low  <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      prev_q <= line_in;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (!busy) begin
        if (enable && prev_q && !line_in) begin
          busy  <= 1'b1;
          cnt_q <= ETU_W'(1);
          bit_q <= '0;
        end
      end else begin
        if (mid) begin
          if (bit_q == 4'd0 && line_in) busy <= 1'b0;            // false start
          else if (bit_q >= 4'd1 && bit_q <= 4'd8) sh_q[idx] <= line_in;
          else if (bit_q == 4'd9) begin
            bad_q <= bad_now;
            if ((!bad_now || blk) && !rx_valid) begin
              rx_valid <= 1'b1;
              rx_data  <= sc_line_map(sh_q, inv);
            end
          end
        end
        if (cnt_q == last) begin
          cnt_q <= '0;
          bit_q <= bit_q + 4'd1;
          if (bit_q == 4'd9) drv_low <= bad_q && !blk;
          if (bit_q == 4'd10) begin
            busy    <= 1'b0;
            drv_low <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sc_xcvr.sv
module sc_xcvr #(
  parameter int ETU_W     = 12,
  parameter int MAX_RETRY = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ETU_W-1:0] cfg_etu_div,
  input  logic             cfg_inverse,
  input  logic             cfg_par_flip,
  input  logic             cfg_block,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data,
  output logic             tx_end,
  output logic             par_err_flag,
  input  logic             par_err_clr,
  output logic             err_sig_flag,
  input  logic             err_sig_clr,
  input  logic             line_in,
  output logic             line_drive_low
);
  logic tx_busy, rx_busy, tx_fire, rx_en;
  logic tx_low, rx_low, ers_set, per_set, ers_q;

  assign tx_ready = !tx_busy && !rx_busy;
  assign tx_fire  = tx_valid && tx_ready;
  assign rx_en    = !tx_busy && !tx_fire;
  assign tx_end   = !tx_busy;
  assign line_drive_low = tx_low | rx_low;
  assign err_sig_flag   = ers_q && !cfg_block;

  sc_tx #(.ETU_W(ETU_W), .MAX_RETRY(MAX_RETRY)) u_tx (
    .clk(clk), .rst_n(rst_n), .etu_div(cfg_etu_div), .inv(cfg_inverse),
    .flip(cfg_par_flip), .blk(cfg_block), .start(tx_fire), .data(tx_data),
    .line_in(line_in), .busy(tx_busy), .drv_low(tx_low), .err_seen(ers_set)
  );

  sc_rx #(.ETU_W(ETU_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .etu_div(cfg_etu_div), .inv(cfg_inverse),
    .flip(cfg_par_flip), .blk(cfg_block), .enable(rx_en), .line_in(line_in),
    .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .busy(rx_busy), .drv_low(rx_low), .par_err(per_set)
  );

  sc_flag u_per (.clk(clk), .rst_n(rst_n), .set(per_set), .clr(par_err_clr), .q(par_err_flag));
  sc_flag u_ers (.clk(clk), .rst_n(rst_n), .set(ers_set), .clr(err_sig_clr), .q(ers_q));
endmodule

// File: rtl/sc_xcvr_chk.sv
module sc_xcvr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_block,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_end,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       par_err_flag,
  input logic       line_drive_low,
  input logic       tx_busy,
  input logic       rx_busy
);
  p_rx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  p_no_tx_during_rx_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy |-> !tx_ready);

  p_idle_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy && !rx_busy |-> !line_drive_low);

  p_accept_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_end && line_drive_low);

  p_blk_no_signal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_block && $past(cfg_block) && !tx_busy |-> !line_drive_low);

  p_per_from_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_err_flag) |-> $past(rx_busy));
endmodule

bind sc_xcvr sc_xcvr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_block(cfg_block), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_end(tx_end), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .par_err_flag(par_err_flag), .line_drive_low(line_drive_low),
  .tx_busy(tx_busy), .rx_busy(rx_busy)
);

// File: tb/sc_xcvr_tb_top.sv
module sc_xcvr_tb_top;
  localparam int D = 8;
  localparam int ETU_W = 12;
  // {inverse, par_flip, block, data, line pattern (bit0 = start)}
  localparam logic [20:0] VEC [6] = '{
    {1'b0, 1'b0, 1'b0, 8'h3B, 10'h276},
    {1'b1, 1'b1, 1'b0, 8'h3F, 10'h206},
    {1'b0, 1'b0, 1'b1, 8'h00, 10'h000},
    {1'b0, 1'b1, 1'b0, 8'hA5, 10'h34A},
    {1'b1, 1'b1, 1'b1, 8'h80, 10'h1FC},
    {1'b0, 1'b0, 1'b1, 8'hFF, 10'h1FE}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ETU_W-1:0] cfg_etu_div = ETU_W'(D);
  logic cfg_inverse = 0, cfg_par_flip = 0, cfg_block = 0;
  logic tx_valid = 0, rx_ready = 0, par_err_clr = 0, err_sig_clr = 0, card_low = 0;
  logic [7:0] tx_data = '0;
  logic tx_ready, rx_valid, tx_end, par_err_flag, err_sig_flag, line_drive_low, line_in;
  logic [7:0] rx_data;
  int n_chk = 0, n_fail = 0;

  assign line_in = !(line_drive_low | card_low);
  always #2 clk = ~clk;

  sc_xcvr #(.ETU_W(ETU_W), .MAX_RETRY(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_etu_div(cfg_etu_div), .cfg_inverse(cfg_inverse),
    .cfg_par_flip(cfg_par_flip), .cfg_block(cfg_block), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .tx_end(tx_end), .par_err_flag(par_err_flag),
    .par_err_clr(par_err_clr), .err_sig_flag(err_sig_flag), .err_sig_clr(err_sig_clr),
    .line_in(line_in), .line_drive_low(line_drive_low)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_to(inout int c, input int t);
    repeat (t - c) @(negedge clk);
    c = t;
  endtask

  // Returns at the negedge that opens the first start-bit cycle.
  task automatic tx_start(input logic [7:0] d);
    @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // Card drives a 10-bit frame; returns at relative cycle 10*D.
  task automatic card_send(input logic [9:0] pat, input bit clr_mid);
    for (int k = 0; k < 10; k++) begin
      card_low = !pat[k];
      if (clr_mid && k == 9) begin
        repeat (D/2) @(negedge clk);
        par_err_clr = 1'b1;
        @(negedge clk);
        par_err_clr = 1'b0;
        repeat (D/2 - 1) @(negedge clk);
      end else begin
        repeat (D) @(negedge clk);
      end
    end
    card_low = 1'b0;
  endtask

  task automatic pop();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic pulse_clr(input bit per);
    if (per) par_err_clr = 1'b1; else err_sig_clr = 1'b1;
    @(negedge clk);
    par_err_clr = 1'b0; err_sig_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R4 watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int c;
    logic [9:0] seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk(tx_end == 1 && tx_ready == 1, "R4 reset idle", {tx_end, tx_ready}, 3);
    chk(rx_valid == 0, "R11 reset rx_valid", rx_valid, 0);
    chk(par_err_flag == 0 && err_sig_flag == 0, "R10 reset flags", {par_err_flag, err_sig_flag}, 0);
    chk(line_drive_low == 0, "R4 reset line released", line_drive_low, 0);

    // Table walk: transmit each vector, then receive it back from the card
    for (int v = 0; v < 6; v++) begin
      int endc;
      cfg_inverse = VEC[v][20]; cfg_par_flip = VEC[v][19]; cfg_block = VEC[v][18];
      endc = cfg_block ? 11*D + D/2 : 12*D;
      tx_start(VEC[v][17:10]);
      c = 0;
      for (int k = 0; k < 10; k++) begin
        wait_to(c, k*D + D/2);
        seen[k] = !line_drive_low;
      end
      chk(seen == VEC[v][9:0], "R1 R2 R3 line pattern", seen, VEC[v][9:0]);
      wait_to(c, endc - 1);
      chk(tx_end == 0, cfg_block ? "R6 tx_end early" : "R4 tx_end early", tx_end, 0);
      wait_to(c, endc);
      chk(tx_end == 1, cfg_block ? "R6 tx_end time" : "R4 tx_end time", tx_end, 1);
      chk(rx_valid == 0, "R12 no loopback", rx_valid, 0);
      repeat (2*D) @(negedge clk);
      card_send(VEC[v][9:0], 1'b0);
      chk(rx_valid == 1 && rx_data == VEC[v][17:10], "R7 R1 R2 received byte", rx_data, VEC[v][17:10]);
      chk(par_err_flag == 0, "R3 good parity", par_err_flag, 0);
      repeat (2*D) @(negedge clk);
      pop();
    end

    // R5: single error signal, resend at 13 etu
    cfg_inverse = 0; cfg_par_flip = 0; cfg_block = 0;
    tx_start(8'h55); c = 0;
    wait_to(c, 10*D); card_low = 1'b1;
    wait_to(c, 11*D); card_low = 1'b0;
    chk(err_sig_flag == 1, "R5 error signal seen", err_sig_flag, 1);
    wait_to(c, 13*D + D/2);
    chk(line_drive_low == 1 && tx_end == 0, "R5 resend start bit", line_drive_low, 1);
    wait_to(c, 25*D - 1);
    chk(tx_end == 0, "R5 resend busy", tx_end, 0);
    wait_to(c, 25*D);
    chk(tx_end == 1, "R5 resend end", tx_end, 1);
    pulse_clr(1'b0);
    chk(err_sig_flag == 0, "R10 err flag clear", err_sig_flag, 0);

    // R5: retry limit
    tx_start(8'h55); c = 0;
    for (int f = 0; f < 4; f++) begin
      wait_to(c, f*13*D + 10*D); card_low = 1'b1;
      wait_to(c, f*13*D + 11*D); card_low = 1'b0;
    end
    wait_to(c, 51*D - 1);
    chk(tx_end == 0, "R5 retry limit busy", tx_end, 0);
    wait_to(c, 51*D);
    chk(tx_end == 1, "R5 retry limit end", tx_end, 1);
    pulse_clr(1'b0);

    // R6/R10: block mode ignores error signal
    cfg_block = 1;
    tx_start(8'h3B); c = 0;
    wait_to(c, 10*D); card_low = 1'b1;
    wait_to(c, 11*D); card_low = 1'b0;
    wait_to(c, 11*D + D/2 - 1);
    chk(tx_end == 0, "R6 block no resend busy", tx_end, 0);
    wait_to(c, 11*D + D/2);
    chk(tx_end == 1, "R6 block no resend end", tx_end, 1);
    chk(err_sig_flag == 0, "R10 block err flag zero", err_sig_flag, 0);

    // R8: normal-mode receive parity error
    cfg_block = 0;
    repeat (2*D) @(negedge clk);
    card_send(10'h076, 1'b0);
    chk(rx_valid == 0, "R8 bad byte not delivered", rx_valid, 0);
    chk(par_err_flag == 1, "R8 parity flag", par_err_flag, 1);
    repeat (D/2) @(negedge clk);
    chk(line_drive_low == 1, "R8 error signal", line_drive_low, 1);
    repeat (D) @(negedge clk);
    chk(line_drive_low == 0, "R8 error signal ends", line_drive_low, 0);
    pulse_clr(1'b1);
    chk(par_err_flag == 0, "R10 parity flag clear", par_err_flag, 0);

    // R9: block-mode receive parity error
    cfg_block = 1;
    repeat (2*D) @(negedge clk);
    card_send(10'h076, 1'b0);
    chk(rx_valid == 1 && rx_data == 8'h3B, "R9 bad byte delivered", rx_data, 8'h3B);
    chk(par_err_flag == 1, "R9 parity flag", par_err_flag, 1);
    repeat (D/2) @(negedge clk);
    chk(line_drive_low == 0, "R9 no error signal", line_drive_low, 0);
    repeat (D) @(negedge clk);
    pop();
    pulse_clr(1'b1);

    // R10: set and clear in the same cycle
    repeat (2*D) @(negedge clk);
    card_send(10'h076, 1'b1);
    chk(par_err_flag == 1, "R10 set beats clear", par_err_flag, 1);
    repeat (2*D) @(negedge clk);
    pop();
    pulse_clr(1'b1);
    chk(par_err_flag == 0, "R10 later clear", par_err_flag, 0);

    // R11/R12: overrun drop and tx_ready during receive
    cfg_block = 0;
    repeat (2*D) @(negedge clk);
    card_send(10'h276, 1'b0);
    chk(tx_ready == 0, "R12 tx_ready low during receive", tx_ready, 0);
    repeat (2*D) @(negedge clk);
    card_send(10'h14A, 1'b0);
    repeat (2*D) @(negedge clk);
    chk(rx_valid == 1 && rx_data == 8'h3B, "R11 overrun keeps first", rx_data, 8'h3B);
    pop();
    chk(rx_valid == 0, "R11 second byte dropped", rx_valid, 0);

    // R7: false start
    card_low = 1'b1;
    repeat (2) @(negedge clk);
    card_low = 1'b0;
    repeat (2*D) @(negedge clk);
    chk(rx_valid == 0 && tx_ready == 1, "R7 false start rejected", {rx_valid, tx_ready}, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule